// File: doc/BRIEF.md
# MDIO PHY Auto-Configuration Master

This block is the station-management master of a multi-port switch. It brings up a contiguous range of external Ethernet PHYs with no software involved. It divides the system clock down to a management clock and drives the shared bidirectional data line with clause-22 management frames. After reset is released it stays silent for a programmable settling delay. It then runs a fixed write script, giving each PHY an ability advertisement and a control value that enables and restarts auto-negotiation.

The pause (flow-control) ability in the advertisement depends on a strap. The strap is captured while reset is held, and any later change to it is disregarded. The advertisement is written once per reset. From then on the block only reads: it polls each PHY's status and link-partner registers without end. From those it maintains a link, speed and duplex flag per port.

With the default parameters, a 50 MHz clock gives a 312.5 kHz management clock, and the first frame starts about 1.6 ms after reset release. PHY addresses 16 to 20 are served.

Top module: `mdio_autocfg`

## Requirements
- R1: `mdc` has a period of CLK_DIV clock cycles and is high for CLK_DIV/2 of them; it is low while reset is held.
- R2: While `rst_n` is low, `mdio_oe` is low (line released), `mdc` is low and every status output is 0.
- R3: No frame is driven during the first START_DELAY clock cycles after reset release; the first frame's preamble starts within START_DELAY+CLK_DIV+4 cycles.
- R4: Each frame is 32 ones, start `01`, opcode (`01` write, `10` read), 5-bit PHY address, 5-bit register address, turnaround (`10` on writes), then 16 data bits, every field MSB first.
- R5: After the delay, for each PHY address from PHY_FIRST up to PHY_LAST in ascending order, register 4 is written with the advertisement and then register 0 is written with 0x1200.
- R6: The advertisement is 0x05E1 when `flow_ctl_strap` is high during reset, and 0x01E1 (bit 10, pause, cleared) when it is low; changes to the strap after reset release have no effect.
- R7: Register 4 of each PHY is written exactly once per reset; every frame after the write script is a read.
- R8: After the script the block repeats forever: for each address in ascending order it reads register 1, then register 5.
- R9: During a read, `mdio_oe` is low from the first turnaround bit to the end of the frame, and the data bits are taken from `mdio_i` at the rising edge of `mdc`.
- R10: After the register-5 read of a port completes, that port's `link_up` equals bit 2 of its last register-1 value, `speed100` equals bit 8 OR bit 7 of register 5, and `full_dup` equals bit 8 OR (bit 6 AND NOT bit 7); status changes only then.
- R11: While `mdio_oe` is high, `mdio_o` changes only on the clock edge where `mdc` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_ctl_strap | input | 1 | Pause-advertisement enable, captured while reset is low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High when the master drives the data line |
| mdio_i | input | 1 | Resolved management data line |
| link_up | output | PHY_LAST-PHY_FIRST+1 | Per-port link flag, bit 0 is PHY_FIRST |
| speed100 | output | PHY_LAST-PHY_FIRST+1 | Per-port 100 Mb/s flag |
| full_dup | output | PHY_LAST-PHY_FIRST+1 | Per-port full-duplex flag |

## Verification
The assertions assume several things about the inputs. CLK_DIV is even and at least 4. `flow_ctl_strap` settles before reset ends. `mdio_i` carries PHY-driven values only while `mdio_oe` is low, and reads the master's own bit or a pulled-up one otherwise. The bench PHY model keeps to this. It drives the line only from the second turnaround bit through the last data bit of a read. It changes its bit just after each rising `mdc`, and models a pull-up at all other times. The strap changes only during reset, except in one deliberate toggle after release that tests whether it is ignored.

// File: rtl/mdio_pkg.sv
// Package: shared types and constants for the MDIO auto-configuration master.
// Assumes clause-22 framing: 32-bit preamble, start, opcode, addresses,
// turnaround and 16 data bits, transmitted MSB first.
package mdio_pkg;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    localparam logic [4:0]  REG_CTRL  = 5'd0;
    localparam logic [4:0]  REG_STAT  = 5'd1;
    localparam logic [4:0]  REG_ADV   = 5'd4;
    localparam logic [4:0]  REG_LPA   = 5'd5;
    localparam logic [15:0] ADV_ALL   = 16'h05E1;
    localparam int          PAUSE_BIT = 10;
    localparam logic [15:0] CTRL_ANEG = 16'h1200;

    // Assemble the serial image of one frame, first bit in the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  ta;
        logic [15:0] d;
        ta = (c.op == OP_WR) ? 2'b10 : 2'b00;
        d  = (c.op == OP_WR) ? c.wdata : 16'h0000;
        return {32'hFFFF_FFFF, 2'b01, c.op, c.phy, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: management clock generator.
// Divides clk by DIV into a registered mdc with 50% duty and gives one-cycle
// event strobes on the clock edges where mdc rises and where it falls.
// Assumes DIV is even and at least 4. mdc is held low in reset.
module mdio_mdc_gen #(
    parameter int DIV = 160
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0] cnt;
    logic [CW:0]   hi_len;

    assign rise_ev = (cnt == CW'(HALF - 1));
    assign fall_ev = (cnt == CW'(DIV - 1));

    // Free-running divider counter and the mdc register it toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= fall_ev ? '0 : cnt + 1'b1;
            if (rise_ev)
                mdc <= 1'b1;
            else if (fall_ev)
                mdc <= 1'b0;
        end
    end

    // Length of the current high phase, kept for the duty check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_len <= '0;
        else if (mdc)
            hi_len <= hi_len + 1'b1;
        else
            hi_len <= '0;
    end

    p_mdc_high_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_len == (CW+1)'(HALF)));

    p_mdc_low_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($past(hi_len) == '0));

endmodule

// File: rtl/mdio_frame_eng.sv
// Module: management frame shifter.
// Takes a command while idle on an mdc falling event and shifts out the 64-bit
// frame one bit per mdc period. Each bit is updated on the falling event.
// For reads it releases the line from the turnaround onward and takes data
// bits on the rising event. done pulses for one cycle after the last bit.
// Assumes start and cmd stay stable until accept is seen.
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_ev,
    input  logic        fall_ev,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        accept,
    output logic        done,
    output logic        busy,
    output logic [15:0] rdata
);
    localparam int IW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] frame;
    logic [IW-1:0]         idx;
    logic                  is_rd;

    // Frame sequencing: load, shift one bit per falling event, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame   <= '0;
            idx     <= '0;
            is_rd   <= 1'b0;
            busy    <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            accept  <= 1'b0;
            done    <= 1'b0;
        end else begin
            accept <= 1'b0;
            done   <= 1'b0;
            if (fall_ev) begin
                if (!busy) begin
                    if (start) begin
                        frame   <= build_frame(cmd);
                        is_rd   <= (cmd.op == OP_RD);
                        idx     <= '0;
                        busy    <= 1'b1;
                        accept  <= 1'b1;
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                end else if (idx == IW'(FRAME_BITS - 1)) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mdio_o  <= 1'b0;
                    mdio_oe <= 1'b0;
                end else begin
                    idx     <= idx + 1'b1;
                    frame   <= {frame[FRAME_BITS-2:0], 1'b0};
                    mdio_o  <= frame[FRAME_BITS-2];
                    mdio_oe <= !is_rd || ((idx + 1'b1) < IW'(TA_POS));
                end
            end
        end
    end

    // Read data capture on rising mdc during the data field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rise_ev && busy && is_rd && (idx >= IW'(DATA_POS)))
            rdata <= {rdata[14:0], mdio_i};
    end

    p_release_ta_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rd && (idx >= IW'(TA_POS))) |-> !mdio_oe);

    p_done_ends_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

endmodule

// File: rtl/mdio_seq.sv
// Module: configuration and polling sequencer.
// Waits START_DELAY cycles after reset. It then writes advertisement and
// control to each PHY address in turn. After that it alternates status and
// link-partner reads per port forever, updating the per-port flags.
// The pause strap is captured while reset is low.
// Assumes the frame engine accepts one command at a time (accept/done).
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int START_DELAY = 80000,
    parameter int PHY_FIRST   = 16,
    parameter int PHY_LAST    = 20,
    localparam int NPORT      = PHY_LAST - PHY_FIRST + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flow_ctl_strap,
    input  logic             accept,
    input  logic             done,
    input  logic             eng_busy,
    input  logic [15:0]      rdata,
    output logic             start,
    output mdio_cmd_t        cmd,
    output logic [NPORT-1:0] link_up,
    output logic [NPORT-1:0] speed100,
    output logic [NPORT-1:0] full_dup
);
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int DW = $clog2(START_DELAY + 1);
    localparam int AW = $clog2(NPORT + 2) + 1;

    typedef enum logic [1:0] {S_WAIT, S_CFG, S_POLL} seq_state_e;

    seq_state_e     state;
    logic [DW-1:0]  dly;
    logic [PW-1:0]  port;
    logic           step;
    logic           inflight;
    logic           fc_q;
    logic           link_tmp;
    logic [15:0]    adv_word;
    logic [AW-1:0]  adv_wr_cnt;

    assign adv_word = fc_q ? ADV_ALL : (ADV_ALL & ~(16'h1 << PAUSE_BIT));
    assign start    = (state != S_WAIT) && !inflight;

    // Command for the current state, port and step.
    always_comb begin
        cmd.phy = 5'(PHY_FIRST) + 5'(port);
        if (state == S_POLL) begin
            cmd.op    = OP_RD;
            cmd.regad = step ? REG_LPA : REG_STAT;
            cmd.wdata = 16'h0000;
        end else begin
            cmd.op    = OP_WR;
            cmd.regad = step ? REG_CTRL : REG_ADV;
            cmd.wdata = step ? CTRL_ANEG : adv_word;
        end
    end

    // Strap capture during reset; stays frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fc_q <= flow_ctl_strap;
    end

    // Delay, script stepping and port walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_WAIT;
            dly      <= '0;
            port     <= '0;
            step     <= 1'b0;
            inflight <= 1'b0;
        end else begin
            if (state == S_WAIT) begin
                if (dly == DW'(START_DELAY - 1))
                    state <= S_CFG;
                else
                    dly <= dly + 1'b1;
            end
            if (accept)
                inflight <= 1'b1;
            if (done) begin
                inflight <= 1'b0;
                step     <= !step;
                if (step) begin
                    if (port == PW'(NPORT - 1)) begin
                        port <= '0;
                        if (state == S_CFG)
                            state <= S_POLL;
                    end else begin
                        port <= port + 1'b1;
                    end
                end
            end
        end
    end

    // Status capture from the two poll reads of each port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_tmp <= 1'b0;
            link_up  <= '0;
            speed100 <= '0;
            full_dup <= '0;
        end else if (done && (state == S_POLL)) begin
            if (!step) begin
                link_tmp <= rdata[2];
            end else begin
                link_up[port]  <= link_tmp;
                speed100[port] <= rdata[8] | rdata[7];
                full_dup[port] <= rdata[8] | (rdata[6] & ~rdata[7]);
            end
        end
    end

    // Count of advertisement writes accepted since reset (checking only).
    always_ff @(posedge clk) begin
        if (!rst_n)
            adv_wr_cnt <= '0;
        else if (accept && (state == S_CFG) && !step)
            adv_wr_cnt <= adv_wr_cnt + 1'b1;
    end

    p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> !eng_busy);

    p_adv_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_wr_cnt <= AW'(NPORT));

    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(link_up) && $stable(speed100) && $stable(full_dup)) |-> $past(done));

endmodule

// File: rtl/mdio_autocfg.sv
// Module: top of the MDIO PHY auto-configuration master.
// Ties together the mdc divider, the frame shifter and the sequencer.
// Assumes mdio_i is the resolved line (pull-up when nobody drives).
module mdio_autocfg
    import mdio_pkg::*;
#(
    parameter int CLK_DIV     = 160,
    parameter int START_DELAY = 80000,
    parameter int PHY_FIRST   = 16,
    parameter int PHY_LAST    = 20,
    localparam int NPORT      = PHY_LAST - PHY_FIRST + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flow_ctl_strap,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i,
    output logic [NPORT-1:0] link_up,
    output logic [NPORT-1:0] speed100,
    output logic [NPORT-1:0] full_dup
);
    logic        rise_ev;
    logic        fall_ev;
    logic        start;
    logic        accept;
    logic        done;
    logic        busy;
    logic [15:0] rdata;
    mdio_cmd_t   cmd;

    mdio_mdc_gen #(.DIV(CLK_DIV)) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_frame_eng u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .start   (start),
        .cmd     (cmd),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .accept  (accept),
        .done    (done),
        .busy    (busy),
        .rdata   (rdata)
    );

    mdio_seq #(
        .START_DELAY (START_DELAY),
        .PHY_FIRST   (PHY_FIRST),
        .PHY_LAST    (PHY_LAST)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .flow_ctl_strap (flow_ctl_strap),
        .accept         (accept),
        .done           (done),
        .eng_busy       (busy),
        .rdata          (rdata),
        .start          (start),
        .cmd            (cmd),
        .link_up        (link_up),
        .speed100       (speed100),
        .full_dup       (full_dup)
    );

    p_reset_release_r2: assert property (@(posedge clk)
        !rst_n |=> (!mdio_oe && !mdc));

    p_change_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && !$stable(mdio_o)) |-> !mdc);

endmodule

// File: tb/mdio_autocfg_tb_top.sv
// Bench: scoreboard of expected frames plus a PHY model that decodes the
// line, answers reads and compares each frame against the queue.
module mdio_autocfg_tb_top;
    localparam int DIV   = 8;
    localparam int DLY   = 300;
    localparam int FIRST = 16;
    localparam int LAST  = 18;
    localparam int N     = LAST - FIRST + 1;

    typedef struct {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] d;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flow_ctl_strap = 1'b1;
    logic         mdc, mdio_o, mdio_oe, mdio_i;
    logic [N-1:0] link_up, speed100, full_dup;
    logic         phy_en = 1'b0;
    logic         phy_bit = 1'b1;

    int    checks = 0;
    int    errors = 0;
    int    r11_viol = 0;
    bit    finished = 0;
    item_t q[$];

    always #4 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_autocfg #(
        .CLK_DIV(DIV), .START_DELAY(DLY), .PHY_FIRST(FIRST), .PHY_LAST(LAST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .flow_ctl_strap(flow_ctl_strap),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .link_up(link_up), .speed100(speed100), .full_dup(full_dup)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [15:0] reg1_val(input int r, input int p);
        return (((r + p) % 2) == 0) ? 16'h782D : 16'h7809;
    endfunction

    function automatic logic [15:0] reg5_val(input int r, input int p);
        case ((r + 2 * p) % 5)
            0:       return 16'h0100;
            1:       return 16'h0080;
            2:       return 16'h0040;
            3:       return 16'h0020;
            default: return 16'h01E0;
        endcase
    endfunction

    // Driver side: expected write script (R5, R6) and poll reads (R8).
    task automatic push_script(input logic [15:0] adv);
        for (int p = 0; p < N; p++) begin
            q.push_back('{2'b01, 5'(FIRST + p), 5'd4, adv});
            q.push_back('{2'b01, 5'(FIRST + p), 5'd0, 16'h1200});
        end
    endtask

    task automatic push_polls(input int rounds);
        for (int r = 0; r < rounds; r++)
            for (int p = 0; p < N; p++) begin
                q.push_back('{2'b10, 5'(FIRST + p), 5'd1, 16'h0});
                q.push_back('{2'b10, 5'(FIRST + p), 5'd5, 16'h0});
            end
    endtask

    task automatic wait_drain(input int limit);
        int n = 0;
        while (q.size() != 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(q.size() == 0, "R8", "expected frames not all seen", q.size(), 0);
    endtask

    // Monitor / PHY model: decodes frames on rising mdc and scores them.
    initial begin
        int          ones = 0;
        int          pos = -1;
        logic [31:0] sh = '0;
        logic        mdc_prev = 1'b0;
        logic        o_prev = 1'b0;
        logic [1:0]  c_op = '0;
        logic [4:0]  c_phy = '0;
        logic [4:0]  c_rg = '0;
        logic [15:0] rdval = '0;
        int          c_port = 0;
        int          rnd[N];
        int          pend = 0;
        int          pport = 0;
        logic        e_link = 0, e_spd = 0, e_dup = 0;
        item_t       it;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ones = 0; pos = -1; phy_en = 0; phy_bit = 1; pend = 0;
                mdc_prev = 0; o_prev = mdio_o;
                for (int i = 0; i < N; i++) rnd[i] = 0;
                continue;
            end
            if (mdio_oe && (mdio_o != o_prev) && mdc) r11_viol++;
            o_prev = mdio_o;
            if (mdc && !mdc_prev) begin
                if (phy_en)
                    chk(!mdio_oe, "R9", "master drives during read data", 1, 0);
                if (pos < 0) begin
                    if (mdio_i) ones++;
                    else if (ones >= 32) begin pos = 32; sh = '0; end
                    else ones = 0;
                end else begin
                    pos++;
                    sh = {sh[30:0], mdio_i};
                end
                if (pos == 45) begin
                    chk(sh[13:12] == 2'b01, "R4", "start bits", sh[13:12], 1);
                    c_op = sh[11:10]; c_phy = sh[9:5]; c_rg = sh[4:0];
                    c_port = int'(c_phy) - FIRST;
                    if (c_port < 0 || c_port >= N) c_port = 0;
                    rdval = (c_rg == 5'd1) ? reg1_val(rnd[c_port], c_port)
                                           : reg5_val(rnd[c_port], c_port);
                end
                if (c_op == 2'b10 && pos >= 46 && pos <= 62) begin
                    phy_en = 1;
                    phy_bit = (pos == 46) ? 1'b0 : rdval[62 - pos];
                end
                if (pos == 63) begin
                    phy_en = 0;
                    if (q.size() != 0) begin
                        it = q.pop_front();
                        chk(c_op == it.op, "R7", "opcode", c_op, it.op);
                        chk(c_phy == it.phy, "R5", "phy address order", c_phy, it.phy);
                        chk(c_rg == it.rg, "R8", "register address", c_rg, it.rg);
                        if (it.op == 2'b01) begin
                            chk(sh[17:16] == 2'b10, "R4", "write turnaround", sh[17:16], 2);
                            chk(sh[15:0] == it.d, "R6", "write data", sh[15:0], it.d);
                        end else begin
                            chk(sh[15:0] == rdval, "R9", "read data on line", sh[15:0], rdval);
                        end
                    end
                    if (c_op == 2'b10 && c_rg == 5'd5) begin
                        e_link = reg1_val(rnd[c_port], c_port)[2];
                        e_spd  = rdval[8] | rdval[7];
                        e_dup  = rdval[8] | (rdval[6] & ~rdval[7]);
                        pport = c_port;
                        pend = 2 * DIV;
                        rnd[c_port]++;
                    end
                    pos = -1; ones = 0;
                end
            end
            mdc_prev = mdc;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    chk(link_up[pport] == e_link, "R10", "link_up", link_up[pport], e_link);
                    chk(speed100[pport] == e_spd, "R10", "speed100", speed100[pport], e_spd);
                    chk(full_dup[pport] == e_dup, "R10", "full_dup", full_dup[pport], e_dup);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
        report();
    end

    // Main sequence.
    initial begin
        int n;
        int hi;
        int lo;
        repeat (5) @(negedge clk);
        chk(mdio_oe == 0, "R2", "oe in reset", mdio_oe, 0);
        chk(mdc == 0, "R1", "mdc in reset", mdc, 0);
        chk(link_up == 0 && speed100 == 0 && full_dup == 0, "R2", "status in reset",
            {link_up, speed100, full_dup}, 0);

        push_script(16'h05E1);
        push_polls(3);
        rst_n = 1'b1;
        n = 0;
        while (!mdio_oe && n < DLY + 10 * DIV) begin @(negedge clk); n++; end
        chk(n >= DLY && n <= DLY + DIV + 4, "R3", "cycles to first frame", n, DLY);

        // R1: measure one mdc high and one low phase.
        while (mdc) @(negedge clk);
        while (!mdc) @(negedge clk);
        hi = 0;
        while (mdc) begin hi++; @(negedge clk); end
        lo = 0;
        while (!mdc) begin lo++; @(negedge clk); end
        chk(hi == DIV / 2, "R1", "mdc high cycles", hi, DIV / 2);
        chk(lo == DIV / 2, "R1", "mdc low cycles", lo, DIV / 2);

        wait_drain(40000);
        repeat (40) @(negedge clk);

        // Second reset: strap low strips pause; later strap changes ignored.
        rst_n = 1'b0;
        flow_ctl_strap = 1'b0;
        repeat (3) @(negedge clk);
        chk(mdio_oe == 0, "R2", "oe in second reset", mdio_oe, 0);
        chk(link_up == 0 && speed100 == 0 && full_dup == 0, "R2", "status cleared",
            {link_up, speed100, full_dup}, 0);
        push_script(16'h01E1);
        push_polls(2);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        flow_ctl_strap = 1'b1;
        wait_drain(40000);

        chk(r11_viol == 0, "R11", "data changes while mdc high", r11_viol, 0);
        report();
    end
endmodule